// File: doc/BRIEF.md
# Open-String Regulation Mask Controller

This block decides which LED current-sink channels of a boost backlight driver take part in the boost feedback loop. A 3-bit select code picks how many channels are enabled. Each channel reports two comparator flags. One says that its pin is near zero volts, which points to an open string. The other says that the pin sits below the 0.5 V regulation target. A digital overvoltage flag, already filtered by hysteresis, marks the moment when the boost output has run away.

On each rising edge of the overvoltage flag, the block samples the near-zero flags of the enabled channels and stores them as the set of removed channels. A removed channel leaves the regulation mask, but it stays in the enable mask, so its sink keeps conducting if the string comes back. A later overvoltage edge stores a fresh sample, which restores any channel whose fault has cleared. Dropping the device enable clears every removal.

The block drives the loop with the channels that are included and below target. The boost has to raise its output while any included pin is below 0.5 V, so the loop effectively regulates on the lowest included pin.

Top module: `strm_ctrl`

## Requirements
- R1: After reset, with enable high and no overvoltage edge seen, no channel is removed, so the regulation mask equals the enable mask.
- R2: While enable is high, a select code c below 6 enables the lowest c+2 channels (bit i of the mask is set when i < c+2). Codes 6 and 7 enable all eight channels.
- R3: While enable is low, the enable mask, the regulation mask and the below-target output are all zero, and the all-open flag is low.
- R4: On a rising edge of the overvoltage flag while enabled, every enabled channel whose near-zero flag is set is absent from the regulation mask from the next cycle on.
- R5: While the overvoltage flag stays high after its rising edge, changes in the near-zero flags do not alter the regulation mask.
- R6: Near-zero flags that change while no overvoltage edge occurs have no effect on the regulation mask.
- R7: A removed channel whose near-zero flag has cleared returns to the regulation mask after the next overvoltage rising edge.
- R8: Holding enable low for at least one clock and then raising it restores every removed channel.
- R9: The below-target output is the set of channels that are in the regulation mask and whose below-target flag is set. The loop-raise output is high exactly when that set is not empty.
- R10: The all-open flag is high exactly when at least one channel is enabled and every enabled channel has been removed.
- R11: A removed channel stays set in the enable mask. A near-zero flag on a channel that is not enabled is never recorded, so enabling that channel later finds it included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Device enable; low clears all removals |
| sel_i | input | 3 | Channel-count select code |
| low_i | input | 8 | Per-channel pin-near-zero comparator flag |
| below_i | input | 8 | Per-channel below-0.5 V comparator flag |
| ovp_i | input | 1 | Overvoltage flag (hysteresis applied upstream) |
| en_mask_o | output | 8 | Enabled sinks, removed or not |
| reg_mask_o | output | 8 | Channels taking part in the feedback loop |
| under_o | output | 8 | Included channels below the regulation target |
| loop_up_o | output | 1 | Boost must raise its output |
| all_open_o | output | 1 | Every enabled channel is removed |

## Verification
The hardest state to reach from the ports is a removal that survives a long overvoltage episode in which the fault flags keep moving. The stimulus raises the overvoltage flag once, then changes the near-zero flags while the flag is still high and again after it falls. Only a second rising edge may change the mask. Restoration by re-enabling is reached by first removing every enabled channel of a small select code, so that all-open rises, and then pulsing enable low for a single clock.

// File: rtl/strm_pkg.sv
package strm_pkg;
  localparam int unsigned STRM_NCH  = 8;
  localparam int unsigned STRM_SELW = 3;
  // Number of channels enabled by the smallest select code
  localparam int unsigned STRM_MIN_CH = 2;
endpackage

// File: rtl/strm_sel_decode.sv
module strm_sel_decode
  import strm_pkg::*;
#(
  parameter int unsigned NCH  = STRM_NCH,
  parameter int unsigned SELW = STRM_SELW
) (
  input  logic            enable_i,
  input  logic [SELW-1:0] sel_i,
  output logic [NCH-1:0]  en_o
);
  // Codes whose count would reach NCH or beyond fall back to all channels
  localparam int LAST_CODE = int'(NCH) - int'(STRM_MIN_CH);

  always_comb begin
    for (int i = 0; i < int'(NCH); i++) begin
      if (int'(sel_i) < LAST_CODE) begin
        en_o[i] = enable_i && (i < int'(sel_i) + int'(STRM_MIN_CH));
      end else begin
        en_o[i] = enable_i;
      end
    end
  end
endmodule

// File: rtl/strm_edge_det.sv
module strm_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o
);
  logic level_q;
  logic level_d;

  always_comb begin
    level_d = level_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
    end else begin
      level_q <= level_d;
    end
  end

  assign rise_o = level_i & ~level_q;
endmodule

// File: rtl/strm_open_track.sv
module strm_open_track
  import strm_pkg::*;
#(
  parameter int unsigned NCH = STRM_NCH
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable_i,
  input  logic           event_i,
  input  logic [NCH-1:0] en_i,
  input  logic [NCH-1:0] low_i,
  output logic [NCH-1:0] removed_o
);
  logic [NCH-1:0] removed_q;
  logic [NCH-1:0] removed_d;
  logic           removed_ce;

  always_comb begin
    removed_ce = !enable_i || event_i;
    if (!enable_i) begin
      removed_d = '0;
    end else begin
      removed_d = en_i & low_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      removed_q <= '0;
    end else if (removed_ce) begin
      removed_q <= removed_d;
    end
  end

  assign removed_o = removed_q;
endmodule

// File: rtl/strm_ctrl.sv
module strm_ctrl
  import strm_pkg::*;
#(
  parameter int unsigned NCH  = STRM_NCH,
  parameter int unsigned SELW = STRM_SELW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable_i,
  input  logic [SELW-1:0] sel_i,
  input  logic [NCH-1:0]  low_i,
  input  logic [NCH-1:0]  below_i,
  input  logic            ovp_i,
  output logic [NCH-1:0]  en_mask_o,
  output logic [NCH-1:0]  reg_mask_o,
  output logic [NCH-1:0]  under_o,
  output logic            loop_up_o,
  output logic            all_open_o
);
  logic [NCH-1:0] en_mask;
  logic [NCH-1:0] removed;
  logic           ovp_evt;

  strm_sel_decode #(.NCH(NCH), .SELW(SELW)) u_dec (
    .enable_i (enable_i),
    .sel_i    (sel_i),
    .en_o     (en_mask)
  );

  strm_edge_det u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (ovp_i),
    .rise_o  (ovp_evt)
  );

  strm_open_track #(.NCH(NCH)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable_i  (enable_i),
    .event_i   (ovp_evt & enable_i),
    .en_i      (en_mask),
    .low_i     (low_i),
    .removed_o (removed)
  );

  logic [NCH-1:0] incl;

  always_comb begin
    incl       = en_mask & ~removed;
    en_mask_o  = en_mask;
    reg_mask_o = incl;
    under_o    = incl & below_i;
    loop_up_o  = |(incl & below_i);
    all_open_o = (|en_mask) && !(|incl);
  end
endmodule

// File: rtl/strm_chk.sv
module strm_chk #(
  parameter int unsigned NCH  = 8,
  parameter int unsigned SELW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            enable_i,
  input logic [SELW-1:0] sel_i,
  input logic [NCH-1:0]  low_i,
  input logic [NCH-1:0]  below_i,
  input logic            ovp_i,
  input logic [NCH-1:0]  en_mask_o,
  input logic [NCH-1:0]  reg_mask_o,
  input logic [NCH-1:0]  under_o,
  input logic            loop_up_o,
  input logic            all_open_o
);
  // R3
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |-> (en_mask_o == '0 && reg_mask_o == '0 && under_o == '0 && !all_open_o));

  // R4
  open_removed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && ovp_i && !$past(ovp_i)) |=> ((reg_mask_o & $past(en_mask_o & low_i)) == '0));

  // R5
  held_ovp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && $past(enable_i) && $past(ovp_i) && $past(ovp_i, 2) && $stable(sel_i))
      |-> $stable(reg_mask_o));

  // R8
  reenable_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enable_i) |-> (reg_mask_o == en_mask_o));

  // R9
  under_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((under_o & ~(reg_mask_o & below_i)) == '0) && (loop_up_o == (under_o != '0)));

  // R10
  all_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    all_open_o |-> (en_mask_o != '0 && reg_mask_o == '0));

  // R11
  removed_stay_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_mask_o & ~en_mask_o) == '0);
endmodule

bind strm_ctrl strm_chk #(.NCH(NCH), .SELW(SELW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable_i   (enable_i),
  .sel_i      (sel_i),
  .low_i      (low_i),
  .below_i    (below_i),
  .ovp_i      (ovp_i),
  .en_mask_o  (en_mask_o),
  .reg_mask_o (reg_mask_o),
  .under_o    (under_o),
  .loop_up_o  (loop_up_o),
  .all_open_o (all_open_o)
);

// File: tb/tb_strm_ctrl.sv
module tb_strm_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       enable_i;
  logic [2:0] sel_i;
  logic [7:0] low_i;
  logic [7:0] below_i;
  logic       ovp_i;
  logic [7:0] en_mask_o;
  logic [7:0] reg_mask_o;
  logic [7:0] under_o;
  logic       loop_up_o;
  logic       all_open_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  strm_ctrl dut (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .sel_i(sel_i),
    .low_i(low_i), .below_i(below_i), .ovp_i(ovp_i),
    .en_mask_o(en_mask_o), .reg_mask_o(reg_mask_o), .under_o(under_o),
    .loop_up_o(loop_up_o), .all_open_o(all_open_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] exp_en(input logic [2:0] c);
    if (c < 3'd6) return 8'((9'd1 << (c + 3'd2)) - 9'd1);
    return 8'hFF;
  endfunction

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic ovp_pulse(input logic [7:0] low);
    low_i = low; ovp_i = 1'b1; step();
    ovp_i = 1'b0; step();
  endtask

  task automatic t_reset();
    chk("R1", "reg_mask after reset", reg_mask_o, 8'hFF);
    chk("R1", "en_mask after reset", en_mask_o, 8'hFF);
  endtask

  task automatic t_decode();
    for (int c = 0; c < 8; c++) begin
      sel_i = 3'(c); step();
      chk("R2", "en_mask decode", en_mask_o, exp_en(3'(c)));
      chk("R2", "reg_mask decode", reg_mask_o, exp_en(3'(c)));
    end
  endtask

  task automatic t_open_detect();
    sel_i = 3'd7; step();
    ovp_pulse(8'h24);
    chk("R4", "open strings removed", reg_mask_o, 8'hDB);
    chk("R11", "removed stay enabled", en_mask_o, 8'hFF);
  endtask

  task automatic t_held_and_quiet();
    low_i = 8'h81; ovp_i = 1'b1; step();
    chk("R4", "removal after rise", reg_mask_o, 8'h7E);
    low_i = 8'h03; step(); step();
    chk("R5", "held ovp ignores low changes", reg_mask_o, 8'h7E);
    ovp_i = 1'b0; low_i = 8'hF0; step(); step();
    chk("R6", "low without ovp edge", reg_mask_o, 8'h7E);
  endtask

  task automatic t_restore();
    ovp_pulse(8'h01);
    chk("R7", "cleared faults restored", reg_mask_o, 8'hFE);
    ovp_pulse(8'h00);
    chk("R7", "all restored", reg_mask_o, 8'hFF);
  endtask

  task automatic t_under();
    ovp_pulse(8'h24);
    below_i = 8'h25; step();
    chk("R9", "under is included and below", under_o, 8'h01);
    chk("R9", "loop_up set", {7'd0, loop_up_o}, 8'h01);
    below_i = 8'h24; step();
    chk("R9", "removed below ignored", under_o, 8'h00);
    chk("R9", "loop_up clear", {7'd0, loop_up_o}, 8'h00);
    below_i = 8'h00; low_i = 8'h00;
    ovp_pulse(8'h00);
  endtask

  task automatic t_disabled_ch();
    sel_i = 3'd0; step();
    ovp_pulse(8'hFC);
    chk("R11", "disabled low ignored sel0", reg_mask_o, 8'h03);
    sel_i = 3'd7; low_i = 8'h00; step();
    chk("R11", "wider select finds all included", reg_mask_o, 8'hFF);
  endtask

  task automatic t_all_open_reenable();
    sel_i = 3'd0; step();
    ovp_pulse(8'h03);
    chk("R10", "all_open set", {7'd0, all_open_o}, 8'h01);
    chk("R10", "reg_mask empty", reg_mask_o, 8'h00);
    below_i = 8'hFF; step();
    chk("R9", "no loop_up when none included", {7'd0, loop_up_o}, 8'h00);
    enable_i = 1'b0; step();
    chk("R3", "disabled en_mask", en_mask_o, 8'h00);
    chk("R3", "disabled under", under_o, 8'h00);
    chk("R3", "disabled all_open", {7'd0, all_open_o}, 8'h00);
    enable_i = 1'b1; step();
    chk("R8", "reenable restores", reg_mask_o, 8'h03);
    chk("R10", "all_open clear", {7'd0, all_open_o}, 8'h00);
    below_i = 8'h00;
  endtask

  initial begin
    rst_n = 1'b0; enable_i = 1'b1; sel_i = 3'd7; low_i = '0; below_i = '0; ovp_i = 1'b0;
    step(); step();
    rst_n = 1'b1; step();
    t_reset();
    t_decode();
    t_open_detect();
    t_held_and_quiet();
    t_restore();
    t_under();
    t_disabled_ch();
    t_all_open_reenable();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule